// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash command port and carries out one of two jobs per start request: erasing the block at a given address, or programming a run of consecutive bytes that it pulls one by one from a valid/ready source. It produces every command write and status read itself. The caller sees a busy level, a one-cycle done pulse and, once done, the final status byte, an error flag, a timeout flag and the address of the last byte it worked on.

The flash port is a simple single-cycle access port. Each cycle with `fl_req` high is one access. `fl_we` selects a write of `fl_wdata` or a read. A read samples `fl_rdata` at the clock edge that ends the access cycle. Status bit 7 means the device is ready. Every operation ends with a status poll, a final status read and a write that returns the device to array mode. A multi-byte program stops early at the first byte whose result shows an error. A programmable poll limit stops a device that never becomes ready.

Top module: `flseq_top`

## Requirements
- R1: While reset is asserted and until the first start, `busy`, `done`, `fl_req`, `src_ready`, `err` and `tmo` are 0 and `status` is 0x00.
- R2: After an erase start (`op_prog`=0), the first three bus cycles are writes of 0x50, then 0x20, then 0xD0, all to `addr`, on consecutive cycles starting the cycle after start is sampled.
- R3: After the 0xD0 write, an erase leaves the bus idle for exactly `ERASE_WAIT` cycles and then writes 0x70 to the same address.
- R4: For each programmed byte (`op_prog`=1), the sequencer first accepts one byte from the source (`src_ready` and `src_valid` both high). It then writes 0x40 and the accepted byte on the next two cycles and a status command 0x70 on the third, all to the same address. Byte k of a run uses address `addr`+k.
- R5: After each 0x70 write, the sequencer reads the same address every cycle until a read returns bit 7 set. It then reads once more, takes that value as `status`, and writes 0xFF in the following cycle.
- R6: `done` is high for exactly one cycle, the cycle after the final 0xFF write. `busy` is high from the cycle after start up to and including the 0xFF write, and low when `done` is high.
- R7: `err` is 1 when status bit 5, 4, 3 or 1 is set (mask 0x3A) or when a timeout occurred; status bits 7, 6 and 2 alone leave it 0.
- R8: A program run stops after the 0xFF write of the first byte whose result has an error, and it fetches no further source bytes. `fail_addr` holds the address of the last byte handled (or the block address for an erase).
- R9: When `poll_limit` consecutive poll reads (a limit of 0 counts as 1) all return bit 7 clear, polling stops. The sequencer writes 0xFF in the next cycle, and after that `tmo`=1, `err`=1 and `status` holds the last polled value.
- R10: A start while `busy` is high has no effect on the bus sequence or the results.
- R11: While the sequencer waits for a source byte (`src_ready` high, `src_valid` low), it makes no bus access and keeps waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start | input | 1 | Start request, sampled while idle |
| op_prog | input | 1 | 1 = program a run of bytes, 0 = erase a block |
| addr | input | AW | Block address or first byte address |
| len | input | LW | Number of bytes to program (0 acts as 1) |
| poll_limit | input | TW | Maximum not-ready status reads per operation |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Sequencer takes a source byte this cycle if valid |
| fl_req | output | 1 | Flash access this cycle |
| fl_we | output | 1 | Access is a write |
| fl_addr | output | AW | Access address |
| fl_wdata | output | 8 | Write byte (command or data) |
| fl_rdata | input | 8 | Read byte from the flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Final status byte |
| err | output | 1 | Error bits set in status, or timeout |
| tmo | output | 1 | Polling stopped by the limit |
| fail_addr | output | AW | Address of the last byte handled |

## Verification
Erases are run with both clean and error results, so the three-write prologue and the idle gap are told apart from the shorter program prologue. Program runs with several busy-poll lengths show that the poll count follows the device and not a fixed count. A source that stalls shows that the fetch wait adds idle cycles without any bus access. Errors injected on a middle byte, in each error bit and in the non-error bits separate a correct early stop from a run that continues, and a wrong mask from a right one. Busy counts just below and at the poll limit separate a ready device from a timed-out one, and a start raised in the middle of a run must leave the per-cycle bus trace unchanged.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CLR, S_ERS, S_CNF, S_WAIT,
    S_PGM, S_DAT, S_RSTAT, S_POLL, S_RES, S_ARRAY
  } seq_state_e;

  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;
  localparam logic [7:0] ERR_MASK  = 8'h3A;
  localparam int         READY_BIT = 7;
endpackage

// File: rtl/flseq_cnt.sv
module flseq_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load | dec) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q <= W'(1));

  // decrement only happens above the last count
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt_q > W'(1)));
endmodule

// File: rtl/flseq_fsm.sv
module flseq_fsm
  import flseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int TW = 16,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_prog,
  input  logic [AW-1:0] addr_in,
  input  logic [TW-1:0] poll_limit,
  input  logic          src_valid,
  input  logic [7:0]    src_data,
  output logic          src_ready,
  output logic          fl_req,
  output logic          fl_we,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic [AW-1:0] addr_o,
  output logic          busy,
  output logic          done,
  output logic [7:0]    status,
  output logic          tmo,
  output logic          err,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_dec,
  input  logic          tmr_last,
  output logic          rem_load,
  output logic          rem_dec,
  input  logic          rem_last
);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(EW);

  seq_state_e    state_q, state_d;
  logic          op_q, op_en;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;
  logic [7:0]    data_q;
  logic          data_en;
  logic [7:0]    stat_q, stat_d;
  logic          stat_en;
  logic          tmo_q, tmo_d, tmo_en;
  logic          done_q, done_d;
  logic          stat_bad;

  assign stat_bad = |(stat_q & ERR_MASK);

  always_comb begin
    state_d  = state_q;
    op_en    = 1'b0;
    addr_en  = 1'b0;
    addr_d   = addr_q;
    data_en  = 1'b0;
    stat_en  = 1'b0;
    stat_d   = stat_q;
    tmo_en   = 1'b0;
    tmo_d    = tmo_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    rem_load = 1'b0;
    rem_dec  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        op_en    = 1'b1;
        addr_en  = 1'b1;
        addr_d   = addr_in;
        rem_load = 1'b1;
        stat_en  = 1'b1;
        stat_d   = '0;
        tmo_en   = 1'b1;
        tmo_d    = 1'b0;
        state_d  = op_prog ? S_FETCH : S_CLR;
      end
      S_FETCH: if (src_valid) begin
        data_en = 1'b1;
        state_d = S_PGM;
      end
      S_CLR: state_d = S_ERS;
      S_ERS: state_d = S_CNF;
      S_CNF: begin
        tmr_load = 1'b1;
        tmr_val  = WAIT_LOAD;
        state_d  = S_WAIT;
      end
      S_WAIT: begin
        if (tmr_last) state_d = S_RSTAT;
        else          tmr_dec = 1'b1;
      end
      S_PGM: state_d = S_DAT;
      S_DAT: state_d = S_RSTAT;
      S_RSTAT: begin
        tmr_load = 1'b1;
        tmr_val  = poll_limit;
        state_d  = S_POLL;
      end
      S_POLL: begin
        if (fl_rdata[READY_BIT]) begin
          state_d = S_RES;
        end else if (tmr_last) begin
          stat_en = 1'b1;
          stat_d  = fl_rdata;
          tmo_en  = 1'b1;
          tmo_d   = 1'b1;
          state_d = S_ARRAY;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      S_RES: begin
        stat_en = 1'b1;
        stat_d  = fl_rdata;
        state_d = S_ARRAY;
      end
      S_ARRAY: begin
        if (!op_q || tmo_q || stat_bad || rem_last) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          rem_dec = 1'b1;
          addr_en = 1'b1;
          addr_d  = addr_q + 1'b1;
          state_d = S_FETCH;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      op_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      stat_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (op_en)   op_q   <= op_prog;
      if (addr_en) addr_q <= addr_d;
      if (data_en) data_q <= src_data;
      if (stat_en) stat_q <= stat_d;
      if (tmo_en)  tmo_q  <= tmo_d;
    end
  end

  always_comb begin
    fl_req    = 1'b1;
    fl_we     = 1'b1;
    fl_wdata  = '0;
    src_ready = 1'b0;
    unique case (state_q)
      S_CLR:          fl_wdata = CMD_CLR;
      S_ERS:          fl_wdata = CMD_ERASE;
      S_CNF:          fl_wdata = CMD_CONF;
      S_PGM:          fl_wdata = CMD_PROG;
      S_DAT:          fl_wdata = data_q;
      S_RSTAT:        fl_wdata = CMD_STAT;
      S_ARRAY:        fl_wdata = CMD_ARRAY;
      S_POLL, S_RES:  fl_we = 1'b0;
      S_FETCH: begin
        fl_req    = 1'b0;
        fl_we     = 1'b0;
        src_ready = 1'b1;
      end
      default: begin
        fl_req = 1'b0;
        fl_we  = 1'b0;
      end
    endcase
  end

  assign addr_o = addr_q;
  assign busy   = (state_q != S_IDLE);
  assign done   = done_q;
  assign status = stat_q;
  assign tmo    = tmo_q;
  assign err    = tmo_q | stat_bad;

  // R2
  erase_conf_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_we && !op_q && fl_wdata == CMD_CONF) |->
      ($past(fl_req) && $past(fl_wdata) == CMD_ERASE && $stable(addr_q)));
  // R4
  prog_data_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DAT) |-> ($past(fl_req) && $past(fl_wdata) == CMD_PROG && $stable(addr_q)));
  // R5
  array_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ARRAY) |-> ($past(fl_req) && !$past(fl_we)));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  tmo_on_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> (state_q == S_ARRAY && !stat_q[READY_BIT]));
  // R11
  fetch_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !fl_req);
endmodule

// File: rtl/flseq_top.sv
module flseq_top #(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int TW = 16,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_prog,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len,
  input  logic [TW-1:0] poll_limit,
  input  logic          src_valid,
  input  logic [7:0]    src_data,
  output logic          src_ready,
  output logic          fl_req,
  output logic          fl_we,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    status,
  output logic          err,
  output logic          tmo,
  output logic [AW-1:0] fail_addr
);
  logic          tmr_load, tmr_dec, tmr_last;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic          rem_load, rem_dec, rem_last;
  logic [LW-1:0] rem_cnt;
  logic [AW-1:0] cur_addr;

  flseq_fsm #(.AW(AW), .TW(TW), .EW(EW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog),
    .addr_in(addr), .poll_limit(poll_limit),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .fl_req(fl_req), .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .addr_o(cur_addr), .busy(busy), .done(done), .status(status),
    .tmo(tmo), .err(err),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_dec(tmr_dec), .tmr_last(tmr_last),
    .rem_load(rem_load), .rem_dec(rem_dec), .rem_last(rem_last)
  );

  flseq_cnt #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .cnt(tmr_cnt), .last(tmr_last)
  );

  flseq_cnt #(.W(LW)) u_rem (
    .clk(clk), .rst_n(rst_n), .load(rem_load), .load_val(len),
    .dec(rem_dec), .cnt(rem_cnt), .last(rem_last)
  );

  assign fl_addr   = cur_addr;
  assign fail_addr = cur_addr;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_req && !src_ready));
  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rem_dec) |=> $stable(rem_cnt));
  // R9
  poll_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_load && !tmr_dec) |=> $stable(tmr_cnt));
endmodule

// File: tb/test_flseq_top.sv
module test_flseq_top;
  localparam int AW = 24;
  localparam int LW = 16;
  localparam int TW = 16;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, op_prog;
  logic [AW-1:0] addr;
  logic [LW-1:0] len;
  logic [TW-1:0] poll_limit;
  logic          src_valid, src_ready;
  logic [7:0]    src_data;
  logic          fl_req, fl_we;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rdata;
  logic          busy, done, err, tmo;
  logic [7:0]    status;
  logic [AW-1:0] fail_addr;

  always #4 clk = ~clk;

  flseq_top #(.AW(AW), .LW(LW), .TW(TW), .EW(EW)) i_flseq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .addr(addr),
    .len(len), .poll_limit(poll_limit), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .busy(busy), .done(done),
    .status(status), .err(err), .tmo(tmo), .fail_addr(fail_addr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model: busy reads return 0x00, then the loaded status
  int         dev_busy_q[$];
  logic [7:0] dev_stat_q[$];
  int         dev_cnt = 0;
  logic [7:0] dev_stat = 8'h00;
  assign fl_rdata = (dev_cnt > 0) ? 8'h00 : dev_stat;
  always @(posedge clk) begin
    if (fl_req) begin
      if (fl_we && fl_wdata == 8'h70) begin
        dev_cnt  <= dev_busy_q.pop_front();
        dev_stat <= dev_stat_q.pop_front();
      end else if (!fl_we && dev_cnt > 0) begin
        dev_cnt <= dev_cnt - 1;
      end
    end
  end

  // byte source with a programmable initial stall per byte
  logic [7:0] src_mem [16];
  int src_rd = 0, src_n = 0, scnt = 0, stall_cfg = 0;
  assign src_valid = (src_rd < src_n) && (scnt >= stall_cfg);
  assign src_data  = src_mem[src_rd[3:0]];
  always @(posedge clk) begin
    if (src_ready) begin
      if (src_valid) begin
        src_rd <= src_rd + 1;
        scnt   <= 0;
      end else begin
        scnt <= scnt + 1;
      end
    end
  end

  // expected per-cycle bus trace: 0 idle, 1 fetch, 2 write, 3 read
  int ek[$];
  int ea[$];
  int ed[$];
  int         cfg_b[8];
  logic [7:0] cfg_s[8];
  logic [7:0] cfg_d[8];

  task automatic push(input int k, input int a, input int d);
    ek.push_back(k); ea.push_back(a); ed.push_back(d);
  endtask

  task automatic plan_one(input bit prog, input int a, input int d, input int b,
                          input logic [7:0] s, input int lim, input int stall,
                          output bit stop, output logic [7:0] st, output bit to);
    int eff;
    eff = (lim < 1) ? 1 : lim;
    if (prog) begin
      repeat (stall + 1) push(1, 0, 0);
      push(2, a, 8'h40);
      push(2, a, d);
    end else begin
      push(2, a, 8'h50);
      push(2, a, 8'h20);
      push(2, a, 8'hD0);
      repeat (EW) push(0, 0, 0);
    end
    push(2, a, 8'h70);
    dev_busy_q.push_back(b);
    dev_stat_q.push_back(s);
    if (b >= eff) begin
      repeat (eff) push(3, a, 0);
      to = 1'b1;
      st = 8'h00;
    end else begin
      repeat (b + 2) push(3, a, 0);
      to = 1'b0;
      st = s;
    end
    push(2, a, 8'hFF);
    stop = to || ((st & 8'h3A) != 0);
  endtask

  task automatic run_op(input string req, input bit prog, input int a, input int n,
                        input int lim, input int stall, input int ign_at);
    bit stop, to;
    logic [7:0] st;
    int last_a, cyc;
    ek.delete(); ea.delete(); ed.delete();
    dev_busy_q.delete(); dev_stat_q.delete();
    for (int i = 0; i < 8; i++) src_mem[i] = cfg_d[i];
    src_rd = 0; scnt = 0; stall_cfg = stall;
    src_n = prog ? n : 0;
    stop = 1'b0; to = 1'b0; st = 8'h00; last_a = a;
    for (int i = 0; i < (prog ? n : 1); i++) begin
      if (!stop) begin
        plan_one(prog, a + i, int'(cfg_d[i]), cfg_b[i], cfg_s[i], lim, stall, stop, st, to);
        last_a = a + i;
      end
    end
    @(negedge clk);
    op_prog = prog; addr = AW'(a); len = LW'(n); poll_limit = TW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (ek.size() > 0) begin
      int k, ea0, ed0;
      longint act, exp;
      k = ek.pop_front(); ea0 = ea.pop_front(); ed0 = ed.pop_front();
      act = (longint'(fl_req) << 10) | (longint'(fl_we) << 9) | (longint'(src_ready) << 8)
          | (fl_we ? longint'(fl_wdata) : 0) | (longint'(busy) << 12);
      case (k)
        0:       exp = (1 << 12);
        1:       exp = (1 << 12) | (1 << 8);
        2:       exp = (1 << 12) | (1 << 10) | (1 << 9) | ed0;
        default: exp = (1 << 12) | (1 << 10);
      endcase
      chk(act == exp, req, "bus cycle", act, exp);
      if (k >= 2) chk(fl_addr == AW'(ea0), req, "bus address", fl_addr, ea0);
      if (cyc == ign_at) begin
        start = 1'b1; op_prog = ~prog; addr = '1; // R10 stimulus
      end else begin
        start = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R6", "done/busy after final write",
        {done, busy}, 2'b10);
    chk(status == st, "R5", "status", status, st);
    chk(err == (to || ((st & 8'h3A) != 0)), "R7", "err", err, to || ((st & 8'h3A) != 0));
    chk(tmo == to, "R9", "tmo", tmo, to);
    chk(fail_addr == AW'(last_a), "R8", "fail_addr", fail_addr, last_a);
    @(negedge clk);
    chk(done == 1'b0 && fl_req == 1'b0 && src_ready == 1'b0, "R6", "done pulse width",
        {done, fl_req, src_ready}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_prog = 1'b0; addr = '0; len = '0; poll_limit = '0;
    for (int i = 0; i < 8; i++) begin cfg_b[i] = 0; cfg_s[i] = 8'h80; cfg_d[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, fl_req, src_ready, err, tmo} == 6'b0 && status == 8'h00, "R1",
        "reset outputs", {busy, done, fl_req, src_ready, err, tmo, status}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fl_req, src_ready, err, tmo} == 6'b0, "R1", "after reset",
        {busy, done, fl_req, src_ready, err, tmo}, 0);

    // R2 R3: clean erase with three busy polls
    cfg_b[0] = 3; cfg_s[0] = 8'h80;
    run_op("R2", 1'b0, 24'h012340, 1, 10, 0, -1);
    // R7: erase reporting bit 5
    cfg_b[0] = 0; cfg_s[0] = 8'hA0;
    run_op("R3", 1'b0, 24'h0A0000, 1, 10, 0, -1);

    // R4: four bytes, varied poll lengths
    cfg_d[0] = 8'h11; cfg_d[1] = 8'h22; cfg_d[2] = 8'h33; cfg_d[3] = 8'h44;
    cfg_b[0] = 1; cfg_b[1] = 0; cfg_b[2] = 2; cfg_b[3] = 5;
    for (int i = 0; i < 4; i++) cfg_s[i] = 8'h80;
    run_op("R4", 1'b1, 24'h000100, 4, 10, 0, -1);

    // R11: stalled source
    cfg_d[0] = 8'hA5; cfg_d[1] = 8'h5A; cfg_d[2] = 8'hC3;
    run_op("R11", 1'b1, 24'h000200, 3, 10, 2, -1);

    // R8: error on third byte stops the run
    cfg_d[0] = 8'h01; cfg_d[1] = 8'h02; cfg_d[2] = 8'h03; cfg_d[3] = 8'h04;
    cfg_b[0] = 1; cfg_b[1] = 1; cfg_b[2] = 1; cfg_b[3] = 1;
    cfg_s[0] = 8'h80; cfg_s[1] = 8'h80; cfg_s[2] = 8'h90; cfg_s[3] = 8'h80;
    run_op("R8", 1'b1, 24'h000300, 4, 10, 0, -1);

    // R7: each error bit alone, then non-error bits
    cfg_b[0] = 0; cfg_d[0] = 8'h5C;
    cfg_s[0] = 8'h88; run_op("R7", 1'b1, 24'h000400, 1, 10, 0, -1);
    cfg_s[0] = 8'h82; run_op("R7", 1'b1, 24'h000401, 1, 10, 0, -1);
    cfg_s[0] = 8'hC4; run_op("R7", 1'b1, 24'h000402, 1, 10, 0, -1);

    // R9: timeout at the limit, and one below it
    cfg_s[0] = 8'h80;
    cfg_b[0] = 20; run_op("R9", 1'b1, 24'h000500, 1, 5, 0, -1);
    cfg_b[0] = 4;  run_op("R9", 1'b1, 24'h000501, 1, 5, 0, -1);
    cfg_b[0] = 3;  run_op("R9", 1'b0, 24'h020000, 1, 0, 0, -1);

    // R10: start raised mid-run
    cfg_d[0] = 8'h66; cfg_d[1] = 8'h77; cfg_b[0] = 2; cfg_b[1] = 2;
    cfg_s[0] = 8'h80; cfg_s[1] = 8'h80;
    run_op("R10", 1'b1, 24'h000600, 2, 10, 0, 5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule